// File: doc/BRIEF.md
# Shared-Period Input Glitch Filter

This block cleans up a bank of already synchronized input pins before the rest of the chip sees them. Three period registers are shared by every pin; each holds a settling time expressed in clock cycles. Each pin picks one of the three periods, or no filtering at all, through a 2-bit code. The high bit of every code sits in one select register and the low bit in a second one, both at the pin's own bit position.

Each pin keeps a private run counter. While the raw level disagrees with the filtered level, the counter advances. When the run reaches the chosen period, the filtered level takes the raw value. Any cycle in which the raw level agrees with the filtered level clears the counter. Software programs the periods and the select codes through a simple word-addressed write port with a combinational read port. How periods are allocated among pins, and how times are converted to cycle counts, is left to software.

Top module: `dbnc_shared_timer_filter`

## Requirements
- R1: After reset, every select register and every period register reads zero and every filtered output is low.
- R2: Word address 0 is the high-bit select register, address 1 is the low-bit select register, and addresses 2, 3 and 4 are the periods for codes 1, 2 and 3. A write updates the addressed register at the next clock edge. The read data shows the addressed register combinationally. Any other address reads zero, and writes to it change nothing.
- R3: A pin whose code {high bit, low bit} is 0 copies its raw level to the filtered output at every clock edge, one cycle behind.
- R4: A pin with code 1, 2 or 3 uses period 1, 2 or 3 respectively as P. Its filtered output changes only to the raw value, and only at the P-th consecutive clock edge at which raw differed from the filtered level.
- R5: Any edge at which raw equals the filtered level clears that pin's run. A pulse shorter than P never reaches the output, and neither does a train of such pulses.
- R6: A selected period of 0 or 1 makes the pin follow raw one cycle behind, the same as code 0.
- R7: Every pin has its own run counter and its own code. Pins using different periods settle independently, and a change on one pin does not disturb another.
- R8: When a period is lowered below a run already in progress, the pin's output takes the raw value at the first edge that evaluates the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (3) | Register word address |
| cfg_wr_data | input | DATA_W (32) | Register write data |
| cfg_rd_data | output | DATA_W (32) | Contents of the addressed register |
| pin_raw | input | NUM_PINS (32) | Synchronized raw pin levels |
| pin_filt | output | NUM_PINS (32) | Filtered pin levels |

## Verification
The bench builds the block at its defaults: 32 pins, 32-bit periods and three timers. It programs periods of only a few cycles, which puts every count boundary, the lowering of a period in the middle of a run, and the zero and one periods within a short run. With 32 pins split across all four codes, slowly flipping random input patterns exercise pins at different periods side by side. A behavioural model then compares every filtered output on every clock.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
    // Word addresses of the configuration registers
    localparam int ADR_SEL_HI   = 0;
    localparam int ADR_SEL_LO   = 1;
    localparam int ADR_PER_BASE = 2;
    // Width of a per-pin timer code (high bit and low bit)
    localparam int CODE_W       = 2;
endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs #(
    parameter int PINS = 32,
    parameter int PW   = 32,
    parameter int NT   = 3,
    parameter int AW   = 3,
    parameter int DW   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wr_data,
    output logic [DW-1:0]          rd_data,
    output logic [PINS-1:0]        sel_hi,
    output logic [PINS-1:0]        sel_lo,
    output logic [NT-1:0][PW-1:0]  periods
);
    import dbnc_pkg::*;

    localparam logic [AW-1:0] A_HI = AW'(ADR_SEL_HI);
    localparam logic [AW-1:0] A_LO = AW'(ADR_SEL_LO);

    typedef struct packed {
        logic [PINS-1:0]       hi;
        logic [PINS-1:0]       lo;
        logic [NT-1:0][PW-1:0] per;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == A_HI) st_d.hi = wr_data[PINS-1:0];
            if (addr == A_LO) st_d.lo = wr_data[PINS-1:0];
            for (int t = 0; t < NT; t++) begin
                if (addr == AW'(ADR_PER_BASE + t)) st_d.per[t] = wr_data[PW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_HI) rd_data = DW'(st_q.hi);
        if (addr == A_LO) rd_data = DW'(st_q.lo);
        for (int t = 0; t < NT; t++) begin
            if (addr == AW'(ADR_PER_BASE + t)) rd_data = DW'(st_q.per[t]);
        end
    end

    assign sel_hi  = st_q.hi;
    assign sel_lo  = st_q.lo;
    assign periods = st_q.per;
endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter #(
    parameter int PW = 32,
    parameter int NT = 3,
    parameter int CW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  raw,
    input  logic [CW-1:0]         code,
    input  logic [NT-1:0][PW-1:0] periods,
    output logic                  filt
);
    typedef struct packed {
        logic          lvl;
        logic [PW-1:0] cnt;
    } pin_t;

    pin_t          st_d, st_q;
    logic [PW-1:0] limit;
    logic [PW:0]   run_next;

    // Code 0 (and any code past the last timer) yields a limit of zero,
    // which makes the pin follow raw at the next edge.
    always_comb begin
        limit = '0;
        for (int t = 0; t < NT; t++) begin
            if (code == CW'(t + 1)) limit = periods[t];
        end
    end

    always_comb begin
        st_d     = st_q;
        run_next = {1'b0, st_q.cnt} + 1'b1;
        if (raw != st_q.lvl) begin
            if (run_next >= {1'b0, limit}) begin
                st_d.lvl = raw;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = run_next[PW-1:0];
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/dbnc_shared_timer_filter.sv
module dbnc_shared_timer_filter #(
    parameter int NUM_PINS   = 32,
    parameter int PERIOD_W   = 32,
    parameter int NUM_TIMERS = 3,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    output logic [DATA_W-1:0]   cfg_rd_data,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_filt
);
    import dbnc_pkg::*;

    logic [NUM_PINS-1:0]                   sel_hi;
    logic [NUM_PINS-1:0]                   sel_lo;
    logic [NUM_TIMERS-1:0][PERIOD_W-1:0]   periods;

    dbnc_regs #(
        .PINS(NUM_PINS), .PW(PERIOD_W), .NT(NUM_TIMERS), .AW(ADDR_W), .DW(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .sel_hi  (sel_hi),
        .sel_lo  (sel_lo),
        .periods (periods)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        dbnc_pin_filter #(.PW(PERIOD_W), .NT(NUM_TIMERS), .CW(CODE_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (pin_raw[p]),
            .code    ({sel_hi[p], sel_lo[p]}),
            .periods (periods),
            .filt    (pin_filt[p])
        );
    end
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker #(
    parameter int NUM_PINS   = 32,
    parameter int NUM_TIMERS = 3,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [DATA_W-1:0]   cfg_wr_data,
    input logic [DATA_W-1:0]   cfg_rd_data,
    input logic [NUM_PINS-1:0] pin_raw,
    input logic [NUM_PINS-1:0] pin_filt,
    input logic [NUM_PINS-1:0] sel_hi,
    input logic [NUM_PINS-1:0] sel_lo
);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(dbnc_pkg::ADR_SEL_HI);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(dbnc_pkg::ADR_PER_BASE + NUM_TIMERS - 1);

    AST_SEL_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == A_HI) |=> sel_hi == $past(cfg_wr_data[NUM_PINS-1:0])); // R2

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr > A_LAST) |-> cfg_rd_data == '0); // R2

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_filt ^ $past(pin_raw)) & ~$past(sel_hi | sel_lo)) == '0); // R3

    AST_CHANGE_TO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_filt ^ $past(pin_filt)) & (pin_filt ^ $past(pin_raw))) == '0); // R4

    AST_HOLD_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (~($past(pin_raw) ^ $past(pin_filt)) & (pin_filt ^ $past(pin_filt))) == '0); // R5
endmodule

bind dbnc_shared_timer_filter dbnc_checker #(
    .NUM_PINS(NUM_PINS), .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dbnc_shared_timer_filter_test.sv
module dbnc_shared_timer_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wr_data = '0;
    logic [DW-1:0] cfg_rd_data;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_filt;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    dbnc_shared_timer_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: per pin, how many consecutive edges raw has
    // disagreed with the expected output.
    logic [31:0] m_hi, m_lo, m_filt;
    logic [31:0] m_per [3];
    longint      m_run [NP];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_filt = '0;
            for (int t = 0; t < 3; t++) m_per[t] = '0;
            for (int i = 0; i < NP; i++) m_run[i] = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                int     code;
                longint need;
                code = {30'b0, m_hi[i], m_lo[i]};
                need = (code == 0) ? 0 : longint'(m_per[code-1]);
                if (pin_raw[i] != m_filt[i]) begin
                    m_run[i] = m_run[i] + 1;
                    if (m_run[i] >= need) begin
                        m_filt[i] = pin_raw[i];
                        m_run[i] = 0;
                    end
                end else begin
                    m_run[i] = 0;
                end
            end
            if (cfg_wr_en) begin
                case (cfg_addr)
                    3'd0: m_hi = cfg_wr_data;
                    3'd1: m_lo = cfg_wr_data;
                    3'd2: m_per[0] = cfg_wr_data;
                    3'd3: m_per[1] = cfg_wr_data;
                    3'd4: m_per[2] = cfg_wr_data;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) check(pin_filt === m_filt, cur_req, "per-cycle filtered output", pin_filt, m_filt);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
        cfg_addr = a;
        #1;
        check(cfg_rd_data === exp, req, "register read", cfg_rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        for (int a = 0; a < 5; a++) rd_chk(AW'(a), '0, "R1");
        check(pin_filt === '0, "R1", "filtered after reset", pin_filt, '0);
        rst_n = 1'b1;
        tick(1);
        check(pin_filt === '0, "R1", "filtered after release", pin_filt, '0);

        // R2: register map
        cur_req = "R2";
        wr(3'd2, 32'd5); wr(3'd3, 32'd2); wr(3'd4, 32'd0);
        rd_chk(3'd2, 32'd5, "R2"); rd_chk(3'd3, 32'd2, "R2"); rd_chk(3'd4, 32'd0, "R2");
        wr(3'd6, 32'hDEAD_BEEF);
        rd_chk(3'd6, '0, "R2"); rd_chk(3'd7, '0, "R2"); rd_chk(3'd0, '0, "R2"); rd_chk(3'd1, '0, "R2");

        // R3: all pins bypassed
        cur_req = "R3";
        for (int k = 0; k < 20; k++) begin pin_raw = $urandom; tick(1); end
        pin_raw = 32'hA5A5_0F0F;
        tick(1);
        check(pin_filt === 32'hA5A5_0F0F, "R3", "bypass copy", pin_filt, 32'hA5A5_0F0F);
        pin_raw = '0;
        tick(1);

        // R4: codes 1/2/3/0 on byte groups (hi=00FFFF00, lo=00FF00FF)
        cur_req = "R4";
        wr(3'd0, 32'h00FF_FF00);
        wr(3'd1, 32'h00FF_00FF);
        rd_chk(3'd0, 32'h00FF_FF00, "R2");
        pin_raw = 32'h0000_0001;
        tick(4);
        check(pin_filt[0] === 1'b0, "R4", "pin0 before 5th edge", {31'b0, pin_filt[0]}, 0);
        tick(1);
        check(pin_filt[0] === 1'b1, "R4", "pin0 at 5th edge", {31'b0, pin_filt[0]}, 1);

        // R5: short pulses never pass
        cur_req = "R5";
        pin_raw[1] = 1'b1; tick(3); pin_raw[1] = 1'b0; tick(1);
        pin_raw[1] = 1'b1; tick(4); pin_raw[1] = 1'b0; tick(6);
        check(pin_filt[1] === 1'b0, "R5", "pulse train blocked", {31'b0, pin_filt[1]}, 0);

        // R7: independent pins with different periods
        cur_req = "R7";
        pin_raw = 32'h0000_0101;
        tick(1);
        check(pin_filt[8] === 1'b0, "R7", "pin8 after 1 edge", {31'b0, pin_filt[8]}, 0);
        tick(1);
        check(pin_filt[8] === 1'b1, "R7", "pin8 after 2 edges", {31'b0, pin_filt[8]}, 1);
        check(pin_filt[0] === 1'b1, "R7", "pin0 undisturbed", {31'b0, pin_filt[0]}, 1);
        for (int k = 0; k < 300; k++) begin
            pin_raw = pin_raw ^ ($urandom & $urandom & $urandom);
            tick(1);
        end

        // R6: period 0 and period 1 follow raw
        cur_req = "R6";
        pin_raw = '0;
        tick(8);
        pin_raw = 32'h0001_0000;
        tick(1);
        check(pin_filt[16] === 1'b1, "R6", "period 0 pass", {31'b0, pin_filt[16]}, 1);
        wr(3'd2, 32'd1);
        pin_raw[0] = 1'b1;
        tick(1);
        check(pin_filt[0] === 1'b1, "R6", "period 1 pass", {31'b0, pin_filt[0]}, 1);

        // R8: lowering a period during a run
        cur_req = "R8";
        wr(3'd2, 32'd10);
        pin_raw[0] = 1'b0;
        tick(6);
        wr(3'd2, 32'd3);
        check(pin_filt[0] === 1'b1, "R8", "old period still in force", {31'b0, pin_filt[0]}, 1);
        tick(1);
        check(pin_filt[0] === 1'b0, "R8", "new shorter period", {31'b0, pin_filt[0]}, 0);
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule